// File: doc/BRIEF.md
# UART Transmit Path with Busy Status

This block turns bytes written by a producer into an asynchronous serial stream. Characters enter a sixteen-entry queue through a valid/ready write port. A shift register takes them out one at a time and sends each as a frame on the transmit line. A frame is a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A bit lasts sixteen pulses of an external oversampling tick. The block does not generate that tick.

The `busy` output covers the whole transmit path. It is high while anything is queued or being serialized. It goes low only once the queue is empty and the final stop bit has left the line. The enable input controls only whether new characters are taken from the queue. The frame in progress always completes, and `busy` does not depend on the enable. Software or a power manager can therefore use `busy` to decide when the line may be shut down.

Top module: `uart_tx_busy`

## Requirements
- R1: In the clock cycle after a write is accepted (`wr_valid` and `wr_ready` both high at a rising edge), `busy` is high.
- R2: `busy` stays high for every tick of every bit of a frame that is being sent.
- R3: `busy` falls only when the queue is empty and the final stop bit is complete. It falls in the clock cycle after the tick that ends the sixteenth tick period of that stop bit, and at that point `txd` is high.
- R4: With `tx_enable` low, `busy` stays high while characters are waiting in the queue, even though nothing is being shifted.
- R5: While `tx_enable` is low, no character is taken from the queue and `txd` stays high. A frame that was already started completes in full.
- R6: A frame is one start bit (0), then N data bits sent least significant bit first, where N = 5 + `cfg_word_len` (00 → 5, 01 → 6, 10 → 7, 11 → 8).
- R7: When `cfg_parity_en` is 1, a parity bit follows the last data bit. With `cfg_parity_odd` = 0, the data bits and the parity bit together hold an even number of ones. With `cfg_parity_odd` = 1, they hold an odd number.
- R8: A frame ends with one stop bit (1) when `cfg_two_stop` = 0 and with two when it is 1.
- R9: Each bit on `txd` lasts exactly 16 `baud16_tick` pulses, however far apart the pulses are. `txd` is high whenever no frame is being sent.
- R10: The queue holds 16 characters and sends them in write order. With 16 characters waiting, `fifo_full` is 1 and `wr_ready` is 0, and any further write is refused. `fifo_empty` is 1 exactly when nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_data | input | 8 | Character to send; bits above the word length are ignored |
| wr_ready | output | 1 | High when the queue can accept a write |
| baud16_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| tx_enable | input | 1 | Allows new characters to start |
| cfg_word_len | input | 2 | Data bits per character minus five |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 1 for odd parity, 0 for even parity |
| cfg_two_stop | input | 1 | 1 for two stop bits, 0 for one |
| txd | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | Transmit path is holding or sending data |
| fifo_full | output | 1 | Queue holds 16 characters |
| fifo_empty | output | 1 | Queue holds no characters |

## Verification
`busy` follows an accepted write by one clock, so the bench checks it at the falling edge right after the write edge. A queued character is loaded on the clock after it reaches the head of an idle queue. After that, `txd` changes only on the rising edge that consumes the sixteenth tick of a bit. The bench records `txd` and `busy` once per tick, at the falling edge just before that tick is consumed, and compares each group of sixteen samples with the expected bit. The bench expects `busy` to fall on the clock that consumes the last stop-bit tick and checks it at the falling edge after that last sample.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int DATA_W        = 8;
    localparam int MIN_WORD      = 5;
    localparam int FRAME_W       = DATA_W + 4;
    localparam int LEN_W         = $clog2(FRAME_W + 1);
    localparam int TICKS_PER_BIT = 16;
    localparam int TICK_W        = $clog2(TICKS_PER_BIT);

    typedef enum logic [1:0] {
        WLEN_5 = 2'd0,
        WLEN_6 = 2'd1,
        WLEN_7 = 2'd2,
        WLEN_8 = 2'd3
    } wlen_e;

    typedef struct packed {
        wlen_e wlen;
        logic  par_en;
        logic  par_odd;
        logic  two_stop;
    } line_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_e;

    function automatic int wlen_bits(wlen_e w);
        return MIN_WORD + int'(w);
    endfunction

    // Assemble a frame: bit 0 is first on the line.
    function automatic frame_t build_frame(logic [DATA_W-1:0] d, line_cfg_t c);
        frame_t f;
        int     pos;
        int     nbits;
        logic   par;
        f.bits = '1;
        f.bits[0] = 1'b0;
        pos   = 1;
        nbits = wlen_bits(c.wlen);
        par   = c.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) begin
                f.bits[pos] = d[i];
                par         = par ^ d[i];
                pos         = pos + 1;
            end
        end
        if (c.par_en) begin
            f.bits[pos] = par;
            pos         = pos + 1;
        end
        pos   = pos + (c.two_stop ? 2 : 1);
        f.len = LEN_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty   = (wr_ptr == rd_ptr);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign bit_done = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    input  logic   tick,
    output logic   txd,
    output logic   active
);
    sh_state_e          state;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   left;
    logic               bit_done;

    utx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .run      (state == SH_SEND),
        .tick     (tick),
        .bit_done (bit_done)
    );

    assign active = (state == SH_SEND);
    assign txd    = active ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            shreg <= '1;
            left  <= '0;
        end else if (load) begin
            state <= SH_SEND;
            shreg <= frame.bits;
            left  <= frame.len;
        end else if (active && bit_done) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) begin
                state <= SH_IDLE;
            end
        end
    end

endmodule

// File: rtl/uart_tx_busy.sv
module uart_tx_busy
    import utx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              baud16_tick,
    input  logic              tx_enable,
    input  logic [1:0]        cfg_word_len,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    output logic              txd,
    output logic              busy,
    output logic              fifo_full,
    output logic              fifo_empty
);
    line_cfg_t         cfg;
    frame_t            next_frame;
    logic [DATA_W-1:0] head;
    logic              fifo_pop;
    logic              sh_active;

    assign cfg.wlen     = wlen_e'(cfg_word_len);
    assign cfg.par_en   = cfg_parity_en;
    assign cfg.par_odd  = cfg_parity_odd;
    assign cfg.two_stop = cfg_two_stop;

    utx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_valid),
        .push_data (wr_data),
        .pop       (fifo_pop),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    assign wr_ready   = !fifo_full;
    assign fifo_pop   = tx_enable && !fifo_empty && !sh_active;
    assign next_frame = build_frame(head, cfg);

    utx_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (fifo_pop),
        .frame  (next_frame),
        .tick   (baud16_tick),
        .txd    (txd),
        .active (sh_active)
    );

    // Whole-path status, independent of the enable.
    assign busy = !fifo_empty || sh_active;

endmodule

// File: rtl/utx_busy_chk.sv
module utx_busy_chk (
    input logic clk,
    input logic rst,
    input logic wr_valid,
    input logic wr_ready,
    input logic baud16_tick,
    input logic tx_enable,
    input logic txd,
    input logic busy,
    input logic fifo_full,
    input logic fifo_empty,
    input logic fifo_pop,
    input logic sh_active
);
    logic pv;

    always_ff @(posedge clk) begin
        if (rst) pv <= 1'b0;
        else     pv <= 1'b1;
    end

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> busy); // R1

    AST_BUSY_FALL_AT_END: assert property (@(posedge clk) disable iff (rst)
        (pv && $fell(busy)) |-> (fifo_empty && txd && $past(baud16_tick))); // R3

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |-> !fifo_pop); // R5

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd); // R9

    AST_TXD_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (pv && !$past(baud16_tick) && $past(sh_active) && sh_active) |-> $stable(txd)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !fifo_pop) |=> fifo_full); // R10

endmodule

bind uart_tx_busy utx_busy_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .baud16_tick (baud16_tick),
    .tx_enable   (tx_enable),
    .txd         (txd),
    .busy        (busy),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .fifo_pop    (fifo_pop),
    .sh_active   (sh_active)
);

// File: tb/uart_tx_busy_tb.sv
module uart_tx_busy_tb;
    localparam int SB = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic       baud16_tick = 1'b0;
    logic       tx_enable = 1'b1;
    logic [1:0] cfg_word_len = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       txd;
    logic       busy;
    logic       fifo_full;
    logic       fifo_empty;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int div_cnt = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    logic s_txd  [SB];
    logic s_busy [SB];
    bit   done = 1'b0;

    always #10 clk = ~clk;

    uart_tx_busy u_dut (
        .clk            (clk),
        .rst            (rst),
        .wr_valid       (wr_valid),
        .wr_data        (wr_data),
        .wr_ready       (wr_ready),
        .baud16_tick    (baud16_tick),
        .tx_enable      (tx_enable),
        .cfg_word_len   (cfg_word_len),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .cfg_two_stop   (cfg_two_stop),
        .txd            (txd),
        .busy           (busy),
        .fifo_full      (fifo_full),
        .fifo_empty     (fifo_empty)
    );

    // Tick source and per-tick line recorder (one sample per consumed tick).
    always @(negedge clk) begin
        bit tick_now;
        tick_now = (div_cnt == 0);
        div_cnt  = (div_cnt + 1 >= tick_div) ? 0 : div_cnt + 1;
        baud16_tick = tick_now;
        if (tick_now && !rst) begin
            s_txd[wr_idx % SB]  = txd;
            s_busy[wr_idx % SB] = busy;
            wr_idx = wr_idx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    function automatic int exp_frame(input logic [7:0] d, input int nb, input bit pe,
                                     input bit po, input bit ts, output logic [15:0] e);
        int  k;
        bit  par;
        e    = '1;
        e[0] = 1'b0;
        k    = 1;
        par  = po;
        for (int i = 0; i < nb; i++) begin
            e[k] = d[i];
            par  = par ^ d[i];
            k++;
        end
        if (pe) begin
            e[k] = par;
            k++;
        end
        k = k + (ts ? 2 : 1);
        return k;
    endfunction

    task automatic set_cfg(input int nb, input bit pe, input bit po, input bit ts);
        @(negedge clk);
        cfg_word_len   = 2'(nb - 5);
        cfg_parity_en  = pe;
        cfg_parity_odd = po;
        cfg_two_stop   = ts;
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic capture(input logic [7:0] d, input int nb, input bit pe, input bit po,
                           input bit ts, input string req);
        logic [15:0] e;
        logic [15:0] got;
        int          len;
        int          start;
        bit          shape_ok;
        bit          busy_ok;
        len = exp_frame(d, nb, pe, po, ts, e);
        while (1) begin
            wait (wr_idx > rd_idx);
            if (s_txd[rd_idx % SB] == 1'b0) break;
            rd_idx++;
        end
        start = rd_idx;
        wait (wr_idx >= start + len * 16);
        shape_ok = 1'b1;
        busy_ok  = 1'b1;
        got      = '1;
        for (int b = 0; b < len; b++) begin
            got[b] = s_txd[(start + b * 16 + 8) % SB];
            for (int t = 0; t < 16; t++) begin
                if (s_txd[(start + b * 16 + t) % SB] !== e[b]) shape_ok = 1'b0;
                if (s_busy[(start + b * 16 + t) % SB] !== 1'b1) busy_ok = 1'b0;
            end
        end
        chk(shape_ok, req, "frame bits (16 ticks each, R9)", got, e);
        chk(busy_ok, "R2", "busy during frame", busy_ok, 1);
        rd_idx = start + len * 16;
    endtask

    task automatic check_busy_fall(input string tag);
        @(negedge clk);
        chk(busy == 1'b0, "R3", {"busy after last stop ", tag}, busy, 0);
        chk(txd == 1'b1, "R9", {"idle line ", tag}, txd, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(txd == 1'b1, "R9", "txd at reset", txd, 1);
        chk(busy == 1'b0, "R3", "busy at reset", busy, 0);
        chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R10", "flags at reset",
            {fifo_full, fifo_empty}, 2'b01);
        chk(wr_ready == 1'b1, "R10", "ready at reset", wr_ready, 1);
    endtask

    task automatic t_basic;
        set_cfg(8, 0, 0, 0);
        rd_idx = wr_idx;
        write_char(8'hA5);
        chk(busy == 1'b1, "R1", "busy cycle after write", busy, 1);
        capture(8'hA5, 8, 0, 0, 0, "R6");
        check_busy_fall("basic");
    endtask

    task automatic t_formats;
        set_cfg(5, 1, 0, 1);
        rd_idx = wr_idx;
        write_char(8'hF3);
        capture(8'hF3, 5, 1, 0, 1, "R7 R8 even/2stop");
        check_busy_fall("5E2");
        set_cfg(6, 1, 1, 0);
        rd_idx = wr_idx;
        write_char(8'h2D);
        capture(8'h2D, 6, 1, 1, 0, "R7 odd");
        check_busy_fall("6O1");
        set_cfg(7, 1, 0, 0);
        rd_idx = wr_idx;
        write_char(8'h7F);
        capture(8'h7F, 7, 1, 0, 0, "R7 even 7bit");
        check_busy_fall("7E1");
    endtask

    task automatic t_slow_tick;
        tick_div = 3;
        set_cfg(8, 1, 1, 1);
        rd_idx = wr_idx;
        write_char(8'h3C);
        capture(8'h3C, 8, 1, 1, 1, "R9 sparse ticks");
        check_busy_fall("sparse");
        tick_div = 1;
    endtask

    task automatic t_fill;
        set_cfg(8, 0, 0, 0);
        tx_enable = 1'b0;
        rd_idx = wr_idx;
        for (int i = 0; i < 16; i++) write_char(8'(i * 8'h13 + 8'h05));
        chk(fifo_full == 1'b1, "R10", "full after 16", fifo_full, 1);
        chk(wr_ready == 1'b0, "R10", "ready low when full", wr_ready, 0);
        wr_valid = 1'b1;
        wr_data  = 8'hEE;
        repeat (3) @(negedge clk);
        wr_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R4", "busy while disabled and queued", busy, 1);
        chk(txd == 1'b1, "R5", "no start while disabled", txd, 1);
        tx_enable = 1'b1;
        for (int i = 0; i < 16; i++) capture(8'(i * 8'h13 + 8'h05), 8, 0, 0, 0, "R10 order");
        check_busy_fall("after drain (refused write absent)");
        chk(fifo_empty == 1'b1, "R10", "empty after drain", fifo_empty, 1);
    endtask

    task automatic t_disable_mid;
        set_cfg(8, 0, 0, 0);
        rd_idx = wr_idx;
        write_char(8'h55);
        write_char(8'hC6);
        tx_enable = 1'b0;
        capture(8'h55, 8, 0, 0, 0, "R5 in-flight completes");
        repeat (40) @(negedge clk);
        chk(txd == 1'b1, "R5", "second held while disabled", txd, 1);
        chk(busy == 1'b1, "R4", "busy with queued char", busy, 1);
        chk(fifo_empty == 1'b0, "R10", "queue still holds char", fifo_empty, 0);
        tx_enable = 1'b1;
        capture(8'hC6, 8, 0, 0, 0, "R5 resumes");
        check_busy_fall("after resume");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_formats();
        t_slow_tick();
        t_fill();
        t_disable_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule